// File: doc/BRIEF.md
# Trap Context-Save Sequencer

This block is the sequencer a small 16-bit processor core runs when it takes a software trap. A trap request carries a 5-bit vector number and the address of the trap instruction. The sequencer flushes the pipeline and clears any pending repeat count. It reads the target address from a vector table, then pushes the core's working registers onto a stack that grows upward. Each push is one 32-bit write.

After the last push it raises the mode-flag updates and the new stack pointer for one cycle. In the following cycle it loads the program counter with the fetched vector and pulses done. The register values are sampled in the cycle the trap is accepted, so the core may keep changing its inputs while the sequence runs. Vector memory and data memory are outside the block and are reached through plain ports. The vector memory returns data one cycle after a read strobe. Data memory accepts a write in any cycle where `mem_rdy` is high.

Top module: `ctx_save_seq`

## Requirements
- R1: A trap request seen while idle is accepted. In the next cycle `flush`, `rpt_clr` and `vec_rd_en` are high for exactly one cycle, and `vec_addr` equals VEC_BASE plus twice the vector number.
- R2: The seventh and last write carries the trap instruction address plus one in bits 21:0, with bits 31:22 zero. This address is taken when the trap is accepted.
- R3: The first write goes to `sp_in + 1` with bit 0 forced to zero. Each later write goes to the previous address plus 2. `sp_out` reaches `sp_in + 13` when the flag updates appear.
- R4: Exactly seven writes are made. In each write, bits 15:0 hold the word for the even address and bits 31:16 hold the word for the next odd address. The (high, low) pairs come in this order: (mtmp, stat0), (acch, accl), (prdh, prdl), (aux1, aux0), (page, stat1), (dbgs, ien), then the return address.
- R5: The register values written are the ones present in the accept cycle. Later changes to the register inputs have no effect on the data written.
- R6: While `mem_wr_en` is high and `mem_rdy` is low, the write address and data hold steady and the sequence does not advance.
- R7: In the cycle after the last write is accepted, `set_irq_mask`, `set_dbg_mask`, `clr_prot_wr`, `clr_loop`, `clr_idle` and `sp_wr` are all high for one cycle.
- R8: In the cycle after the flag updates, `pc_load` and `done` pulse for one cycle, and `pc_out` equals the word the vector memory returned.
- R9: Vector 0 runs the same full save sequence and jumps to the word stored at VEC_BASE. It raises no other output.
- R10: `trap_req` is ignored from the accept cycle until the cycle after `done`. A request held high throughout gives a single sequence, and a new one starts only once the block is idle again.
- R11: After reset `busy` is low and every strobe and pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Software trap request |
| trap_vec | input | 5 | Vector number |
| trap_pc | input | 22 | Address of the trap instruction |
| ctx_mtmp | input | 16 | Multiplier temp register |
| ctx_stat0 | input | 16 | Status word 0 |
| ctx_acch | input | 16 | Accumulator high half |
| ctx_accl | input | 16 | Accumulator low half |
| ctx_prdh | input | 16 | Product register high half |
| ctx_prdl | input | 16 | Product register low half |
| ctx_aux0 | input | 16 | Auxiliary register 0 |
| ctx_aux1 | input | 16 | Auxiliary register 1 |
| ctx_page | input | 16 | Data page register |
| ctx_stat1 | input | 16 | Status word 1 |
| ctx_dbgs | input | 16 | Debug status word |
| ctx_ien | input | 16 | Interrupt enable word |
| sp_in | input | 16 | Current stack pointer |
| vec_rd_en | output | 1 | Vector table read strobe |
| vec_addr | output | 22 | Vector table address |
| vec_rd_data | input | 22 | Vector word, valid one cycle after the strobe |
| mem_wr_en | output | 1 | 32-bit stack write request |
| mem_wr_addr | output | 16 | Even word address of the write |
| mem_wr_data | output | 32 | Write data, low half to the even address |
| mem_rdy | input | 1 | Memory accepts the write this cycle |
| sp_out | output | 16 | Updated stack pointer |
| sp_wr | output | 1 | Load strobe for sp_out |
| pc_out | output | 22 | New program counter |
| pc_load | output | 1 | Load strobe for pc_out |
| flush | output | 1 | Pipeline flush pulse |
| rpt_clr | output | 1 | Clear repeat counter pulse |
| set_irq_mask | output | 1 | Set the global maskable-interrupt mask |
| set_dbg_mask | output | 1 | Set the debug-event mask |
| clr_prot_wr | output | 1 | Clear the protected-register write enable |
| clr_loop | output | 1 | Clear the loop flag |
| clr_idle | output | 1 | Clear the idle-status flag |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Sequence finished, with pc_load |

## Verification
The hardest situation to reach is a save that stalls several times in a row on `mem_rdy`. During such a stall the register inputs and `trap_req` change, and the held write must still hold the values from the accept cycle. The stimulus drives `mem_rdy` from a shift-register pattern that gives runs of low cycles. While the sequence runs, it scrambles every register input on each cycle and pulses or holds `trap_req`. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/ctxsave_pkg.sv
package ctxsave_pkg;

    localparam int DW    = 16;
    localparam int SAW   = 16;
    localparam int PCW   = 22;
    localparam int VNW   = 5;
    localparam int NPAIR = 7;
    localparam int IDXW  = $clog2(NPAIR);
    localparam int FLAGN = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_VWAIT,
        ST_SAVE,
        ST_FLAGS,
        ST_JUMP
    } seq_state_e;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } word_pair_t;

    typedef struct packed {
        logic [DW-1:0] mtmp;
        logic [DW-1:0] stat0;
        logic [DW-1:0] acch;
        logic [DW-1:0] accl;
        logic [DW-1:0] prdh;
        logic [DW-1:0] prdl;
        logic [DW-1:0] aux0;
        logic [DW-1:0] aux1;
        logic [DW-1:0] page;
        logic [DW-1:0] stat1;
        logic [DW-1:0] dbgs;
        logic [DW-1:0] ien;
    } core_regs_t;

    typedef struct packed {
        logic set_irq_mask;
        logic set_dbg_mask;
        logic clr_prot_wr;
        logic clr_loop;
        logic clr_idle;
    } flag_upd_t;

    // Pair k of the push order; the return address goes last.
    function automatic word_pair_t pick_pair(input core_regs_t r,
                                             input logic [PCW-1:0] ret,
                                             input int k);
        word_pair_t p;
        logic [2*DW-1:0] rw;
        rw = {{(2*DW-PCW){1'b0}}, ret};
        case (k)
            0:       p = '{hi: r.mtmp, lo: r.stat0};
            1:       p = '{hi: r.acch, lo: r.accl};
            2:       p = '{hi: r.prdh, lo: r.prdl};
            3:       p = '{hi: r.aux1, lo: r.aux0};
            4:       p = '{hi: r.page, lo: r.stat1};
            5:       p = '{hi: r.dbgs, lo: r.ien};
            default: p = '{hi: rw[2*DW-1:DW], lo: rw[DW-1:0]};
        endcase
        return p;
    endfunction

    function automatic logic [PCW-1:0] vec_entry_addr(input logic [PCW-1:0] base,
                                                      input logic [VNW-1:0] vn);
        return base + PCW'({vn, 1'b0});
    endfunction

endpackage

// File: rtl/ctx_snapshot.sv
module ctx_snapshot
    import ctxsave_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  core_regs_t             regs_in,
    input  logic [PCW-1:0]         trap_pc,
    input  logic [IDXW-1:0]        idx,
    output word_pair_t             pair_out
);
    core_regs_t     regs_q;
    logic [PCW-1:0] ret_q;
    word_pair_t     pairs [NPAIR];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
            ret_q  <= '0;
        end else if (load) begin
            regs_q <= regs_in;
            ret_q  <= trap_pc + PCW'(1);
        end
    end

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        assign pairs[k] = pick_pair(regs_q, ret_q, k);
    end

    always_comb begin
        pair_out = pairs[NPAIR-1];
        for (int k = 0; k < NPAIR; k++) begin
            if (idx == IDXW'(k)) pair_out = pairs[k];
        end
    end
endmodule

// File: rtl/ctx_sp_track.sv
module ctx_sp_track
    import ctxsave_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           init,
    input  logic           step,
    input  logic [SAW-1:0] sp_in,
    output logic [SAW-1:0] sp_cur,
    output logic [SAW-1:0] wr_addr
);
    always_ff @(posedge clk) begin
        if (rst)       sp_cur <= '0;
        else if (init) sp_cur <= sp_in + SAW'(1);
        else if (step) sp_cur <= sp_cur + SAW'(2);
    end

    // 32-bit accesses ignore the stack pointer's low bit.
    assign wr_addr = {sp_cur[SAW-1:1], 1'b0};

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        step |=> wr_addr == $past(wr_addr) + SAW'(2));
endmodule

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
    import ctxsave_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_req,
    input  logic            mem_rdy,
    output seq_state_e      state,
    output logic [IDXW-1:0] idx,
    output logic            accept,
    output logic            step
);
    localparam logic [IDXW-1:0] LAST = IDXW'(NPAIR - 1);

    logic last_ok;

    assign accept  = (state == ST_IDLE) && trap_req;
    assign last_ok = (state == ST_SAVE) && mem_rdy && (idx == LAST);
    assign step    = (state == ST_SAVE) && mem_rdy && (idx != LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (trap_req) state <= ST_FETCH;
                ST_FETCH: state <= ST_VWAIT;
                ST_VWAIT: begin
                    state <= ST_SAVE;
                    idx   <= '0;
                end
                ST_SAVE: begin
                    if (last_ok)   state <= ST_FLAGS;
                    else if (step) idx   <= idx + IDXW'(1);
                end
                ST_FLAGS: state <= ST_JUMP;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    p_flags_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLAGS) |-> $past(state == ST_SAVE && mem_rdy));
endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
    import ctxsave_pkg::*;
#(
    parameter logic [PCW-1:0] VEC_BASE = 22'h000D00
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_req,
    input  logic [4:0]      trap_vec,
    input  logic [21:0]     trap_pc,
    input  logic [15:0]     ctx_mtmp,
    input  logic [15:0]     ctx_stat0,
    input  logic [15:0]     ctx_acch,
    input  logic [15:0]     ctx_accl,
    input  logic [15:0]     ctx_prdh,
    input  logic [15:0]     ctx_prdl,
    input  logic [15:0]     ctx_aux0,
    input  logic [15:0]     ctx_aux1,
    input  logic [15:0]     ctx_page,
    input  logic [15:0]     ctx_stat1,
    input  logic [15:0]     ctx_dbgs,
    input  logic [15:0]     ctx_ien,
    input  logic [15:0]     sp_in,
    output logic            vec_rd_en,
    output logic [21:0]     vec_addr,
    input  logic [21:0]     vec_rd_data,
    output logic            mem_wr_en,
    output logic [15:0]     mem_wr_addr,
    output logic [31:0]     mem_wr_data,
    input  logic            mem_rdy,
    output logic [15:0]     sp_out,
    output logic            sp_wr,
    output logic [21:0]     pc_out,
    output logic            pc_load,
    output logic            flush,
    output logic            rpt_clr,
    output logic            set_irq_mask,
    output logic            set_dbg_mask,
    output logic            clr_prot_wr,
    output logic            clr_loop,
    output logic            clr_idle,
    output logic            busy,
    output logic            done
);
    seq_state_e      state;
    logic [IDXW-1:0] idx;
    logic            accept, step;
    core_regs_t      regs_in;
    word_pair_t      pair;
    logic [VNW-1:0]  vn_q;
    logic [PCW-1:0]  vec_q;
    flag_upd_t       fl;

    assign regs_in = '{mtmp: ctx_mtmp, stat0: ctx_stat0, acch: ctx_acch,
                       accl: ctx_accl, prdh: ctx_prdh, prdl: ctx_prdl,
                       aux0: ctx_aux0, aux1: ctx_aux1, page: ctx_page,
                       stat1: ctx_stat1, dbgs: ctx_dbgs, ien: ctx_ien};

    ctx_seq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .trap_req(trap_req), .mem_rdy(mem_rdy),
        .state(state), .idx(idx), .accept(accept), .step(step)
    );

    ctx_snapshot u_snap (
        .clk(clk), .rst(rst), .load(accept), .regs_in(regs_in),
        .trap_pc(trap_pc), .idx(idx), .pair_out(pair)
    );

    ctx_sp_track u_sp (
        .clk(clk), .rst(rst), .init(accept), .step(step), .sp_in(sp_in),
        .sp_cur(sp_out), .wr_addr(mem_wr_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vn_q  <= '0;
            vec_q <= '0;
        end else begin
            if (accept)              vn_q  <= trap_vec;
            if (state == ST_VWAIT)   vec_q <= vec_rd_data;
        end
    end

    always_comb begin
        fl = '0;
        if (state == ST_FLAGS) fl = '1;
    end

    assign vec_rd_en    = (state == ST_FETCH);
    assign vec_addr     = vec_entry_addr(VEC_BASE, vn_q);
    assign flush        = (state == ST_FETCH);
    assign rpt_clr      = (state == ST_FETCH);
    assign mem_wr_en    = (state == ST_SAVE);
    assign mem_wr_data  = pair;
    assign sp_wr        = (state == ST_FLAGS);
    assign set_irq_mask = fl.set_irq_mask;
    assign set_dbg_mask = fl.set_dbg_mask;
    assign clr_prot_wr  = fl.clr_prot_wr;
    assign clr_loop     = fl.clr_loop;
    assign clr_idle     = fl.clr_idle;
    assign pc_load      = (state == ST_JUMP);
    assign done         = (state == ST_JUMP);
    assign pc_out       = vec_q;
    assign busy         = (state != ST_IDLE);

    p_flush_on_start_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> flush && vec_rd_en);

    p_wr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && !mem_rdy) |=> mem_wr_en && $stable(mem_wr_addr) && $stable(mem_wr_data));

    p_pc_after_flags_r8: assert property (@(posedge clk) disable iff (rst)
        set_irq_mask |=> pc_load && done && !set_irq_mask);

    p_single_flush_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush);
endmodule

// File: tb/test_ctx_save_seq.sv
module test_ctx_save_seq;
    localparam logic [21:0] BASE = 22'h000D00;

    logic clk = 0;
    logic rst = 1;
    always #5 clk = ~clk;

    logic        trap_req = 0;
    logic [4:0]  trap_vec = 0;
    logic [21:0] trap_pc = 0;
    logic [15:0] rv [12];
    logic [15:0] sp_in = 0;
    logic        vec_rd_en, mem_wr_en, mem_rdy, sp_wr, pc_load, flush, rpt_clr;
    logic        set_irq_mask, set_dbg_mask, clr_prot_wr, clr_loop, clr_idle, busy, done;
    logic [21:0] vec_addr, vec_rd_data, pc_out;
    logic [15:0] mem_wr_addr, sp_out;
    logic [31:0] mem_wr_data;

    ctx_save_seq #(.VEC_BASE(BASE)) i_ctx_save_seq (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_vec(trap_vec), .trap_pc(trap_pc),
        .ctx_mtmp(rv[0]), .ctx_stat0(rv[1]), .ctx_acch(rv[2]), .ctx_accl(rv[3]),
        .ctx_prdh(rv[4]), .ctx_prdl(rv[5]), .ctx_aux0(rv[6]), .ctx_aux1(rv[7]),
        .ctx_page(rv[8]), .ctx_stat1(rv[9]), .ctx_dbgs(rv[10]), .ctx_ien(rv[11]),
        .sp_in(sp_in), .vec_rd_en(vec_rd_en), .vec_addr(vec_addr), .vec_rd_data(vec_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_rdy(mem_rdy), .sp_out(sp_out), .sp_wr(sp_wr), .pc_out(pc_out),
        .pc_load(pc_load), .flush(flush), .rpt_clr(rpt_clr), .set_irq_mask(set_irq_mask),
        .set_dbg_mask(set_dbg_mask), .clr_prot_wr(clr_prot_wr), .clr_loop(clr_loop),
        .clr_idle(clr_idle), .busy(busy), .done(done)
    );

    int tests = 0, fails = 0;

    function automatic logic [21:0] vtab(input logic [21:0] a);
        return (a * 22'd37) ^ 22'h2A5C3;
    endfunction

    // vector memory, one cycle latency
    logic [21:0] vmem_q = 0;
    always @(posedge clk) if (vec_rd_en) vmem_q <= vtab(vec_addr);
    assign vec_rd_data = vmem_q;

    // memory ready pattern
    logic       stall_mode = 0;
    logic [7:0] lf = 8'h5B;
    logic       rdy_q = 1;
    always @(negedge clk) begin
        lf    <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        rdy_q <= stall_mode ? (lf[0] & lf[2]) : 1'b1;
    end
    assign mem_rdy = rdy_q;

    // behavioural reference model: phase 0 idle,1 fetch,2 wait,3 save,4 flags,5 jump
    int          mph = 0, mk = 0, nwr = 0;
    logic [15:0] msp = 0;
    logic [31:0] mq [7];
    logic [21:0] mvd = 0;
    logic [4:0]  mv = 0;

    always @(posedge clk) begin
        if (rst) begin
            mph = 0; mk = 0;
        end else begin
            case (mph)
                0: if (trap_req) begin
                    mq[0] = {rv[0], rv[1]};   mq[1] = {rv[2], rv[3]};
                    mq[2] = {rv[4], rv[5]};   mq[3] = {rv[7], rv[6]};
                    mq[4] = {rv[8], rv[9]};   mq[5] = {rv[10], rv[11]};
                    mq[6] = {10'd0, trap_pc + 22'd1};
                    mv = trap_vec; msp = sp_in + 16'd1; mk = 0; mph = 1;
                end
                1: mph = 2;
                2: begin mvd = vtab(BASE + 22'(mv) * 22'd2); mph = 3; end
                3: if (mem_rdy) begin
                    nwr++;
                    if (mk == 6) mph = 4;
                    else begin mk++; msp = msp + 16'd2; end
                end
                4: mph = 5;
                default: mph = 0;
            endcase
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    logic [15:0] last_sp = 0;
    int done_cnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            chk(busy == (mph != 0), "R10 busy", busy, mph != 0);
            chk({flush, rpt_clr, vec_rd_en} == {3{mph == 1}}, "R1 flush/rpt/vec strobe",
                {flush, rpt_clr, vec_rd_en}, {3{mph == 1}});
            if (mph == 1) chk(vec_addr == BASE + 22'(mv) * 22'd2, "R1 vec_addr", vec_addr, BASE + 22'(mv) * 22'd2);
            chk(mem_wr_en == (mph == 3), "R6 mem_wr_en", mem_wr_en, mph == 3);
            if (mph == 3) begin
                chk(mem_wr_addr == {msp[15:1], 1'b0}, "R3 write address", mem_wr_addr, {msp[15:1], 1'b0});
                chk(mem_wr_data == mq[mk], (mk == 6) ? "R2 return address" : "R4/R5 pair data",
                    mem_wr_data, mq[mk]);
            end
            chk({set_irq_mask, set_dbg_mask, clr_prot_wr, clr_loop, clr_idle, sp_wr} == {6{mph == 4}},
                "R7 flag pulses", {set_irq_mask, set_dbg_mask, clr_prot_wr, clr_loop, clr_idle, sp_wr},
                {6{mph == 4}});
            if (mph == 4) chk(sp_out == msp, "R3 sp_out", sp_out, msp);
            chk({pc_load, done} == {2{mph == 5}}, "R8 pc_load/done", {pc_load, done}, {2{mph == 5}});
            if (mph == 5) begin
                chk(pc_out == mvd, "R8 pc_out", pc_out, mvd);
                last_sp = sp_out;
                done_cnt++;
            end
        end
    end

    task automatic scramble();
        for (int i = 0; i < 12; i++) rv[i] = 16'($urandom);
    endtask

    task automatic run_trap(input logic [4:0] v, input logic [21:0] pc, input logic [15:0] sp,
                            input logic hold);
        int n;
        int d0;
        d0 = done_cnt;
        nwr = 0;
        @(negedge clk);
        trap_vec = v; trap_pc = pc; sp_in = sp; trap_req = 1;
        @(negedge clk);
        trap_req = hold;
        n = 0;
        while (done_cnt == d0 && n < 500) begin
            @(negedge clk);
            scramble();
            trap_vec = 5'($urandom); trap_pc = 22'($urandom); sp_in = 16'($urandom);
            trap_req = hold | 1'($urandom);
            n++;
        end
        trap_req = 0;
        chk(done_cnt == d0 + 1, "R8 sequence finished once", done_cnt - d0, 1);
        chk(nwr == 7, "R4 write count", nwr, 7);
        chk(last_sp == sp + 16'd13, "R3 final sp", last_sp, sp + 16'd13);
        @(negedge clk);
        if (!hold) chk(busy == 0, "R10 idle after done", busy, 0);
        @(negedge clk);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 12; i++) rv[i] = 16'(i * 16'h1111);
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({busy, flush, rpt_clr, vec_rd_en, mem_wr_en, sp_wr, pc_load, done,
             set_irq_mask, set_dbg_mask, clr_prot_wr, clr_loop, clr_idle} == 0,
            "R11 reset outputs", {busy, mem_wr_en, pc_load, done}, 0);
        rst = 0;
        @(negedge clk);
        chk(busy == 0, "R11 idle after reset", busy, 0);

        run_trap(5'd7, 22'h012340, 16'h0400, 0);          // ready always
        stall_mode = 1;
        run_trap(5'd31, 22'h3FFFFF, 16'h07FF, 0);         // stalls, odd SP, pc wrap
        run_trap(5'd0, 22'h000100, 16'h0010, 0);          // R9 vector 0
        chk(pc_out == vtab(BASE), "R9 vector 0 target", pc_out, vtab(BASE));
        run_trap(5'd12, 22'h00ABCD, 16'hFFF0, 1);         // R10 request held high
        trap_req = 0;
        repeat (40) @(negedge clk);
        stall_mode = 0;
        run_trap(5'd19, 22'h2000AA, 16'h1235, 0);
        repeat (5) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule